// File: doc/BRIEF.md
# Channel-Associated Signalling Debouncer

This block stores the four channel-associated signalling bits (A, B, C and D) for each of the 30 voice channels of an E1 link. An upstream extractor writes one received nibble at a time, tagged with its channel number. The block keeps a candidate nibble and a stability counter for every channel. A candidate becomes the accepted value only after it has stayed unchanged across a run of multiframe ticks, so a single bit error on the line cannot disturb a call that is in progress.

Each channel also carries a valid flag. The flag is tied to receiver frame synchronization. In debounce mode the accepted bits survive a short loss of sync, and the flag is withdrawn only once the hold interval has run out. In bypass mode nibbles are taken at once and the flag drops as soon as sync goes away. A combinational read port returns the accepted nibble and the flag of any channel.

Top module: `cas_debouncer`

## Requirements
- R1: After reset every channel reads nibble 0 with the valid flag low.
- R2: Only channel numbers 1 to 30 address storage. A write to any other number changes no channel, and a read of any other number returns nibble 0 with valid low.
- R3: With debounce off and sync present, a write is readable from the clock after the write, with valid high.
- R4: With debounce on, a nibble that differs from a channel's candidate replaces the candidate and restarts its count. It becomes the accepted value on the fourth tick after that write and not before. With 2 ms ticks this is 6 to 8 ms.
- R5: With debounce on, a nibble that is replaced before it is accepted never reaches the read port.
- R6: With debounce on and sync lost, accepted nibbles and valid flags are held through the first two ticks of the loss. Every valid flag clears on the clock after the third tick.
- R7: With debounce off, every valid flag clears on the clock after sync goes low.
- R8: While sync is low, no accepted nibble changes, but candidates and their counts keep tracking writes and ticks. After sync returns, the first tick that finds a settled candidate loads that candidate and sets valid.
- R9: A valid flag is only ever set while sync is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for a received nibble |
| wr_ch | input | 5 | Channel number of the write |
| wr_nib | input | 4 | Received ABCD nibble, A in bit 3 |
| tick | input | 1 | One-cycle pulse every 2 ms multiframe |
| deb_en | input | 1 | 1 = debounce mode, 0 = bypass mode |
| sync_ok | input | 1 | Receiver is frame-synchronized |
| rd_ch | input | 5 | Channel number to read |
| rd_nib | output | 4 | Accepted nibble of rd_ch |
| rd_valid | output | 1 | Valid flag of rd_ch |

## Verification
The assertions assume that tick is a single-cycle pulse and that deb_en changes only when no write or tick happens in the same cycle. Otherwise the check that ties an accepted change to a settled tick could see a bypass write as a debounce update. The bench drives wr_en, tick, deb_en and sync_ok only at falling edges. It never raises two of them in the same cycle, and it switches modes only while the block is idle. Within these limits it sweeps all 30 channels and the two neighbouring out-of-range numbers.

// File: rtl/cas_db_pkg.sv
package cas_db_pkg;

  // Saturating increment used by the stability and loss counters.
  function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic [7:0] lim);
    return (v >= lim) ? lim : v + 8'd1;
  endfunction

  // True when a candidate has sat unchanged for the full settle count.
  function automatic logic settled(input logic [7:0] cnt, input logic [7:0] lim);
    return cnt == lim;
  endfunction

endpackage

// File: rtl/cas_db_loss_timer.sv
module cas_db_loss_timer
  import cas_db_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync_ok,
  output logic hold_expired
);
  localparam int unsigned LW = $clog2(HOLD_TICKS + 1);

  logic [LW-1:0] lost_q;

  always_ff @(posedge clk) begin
    if (!rst_n || sync_ok) lost_q <= '0;
    else if (tick)         lost_q <= LW'(sat_inc(8'(lost_q), 8'(HOLD_TICKS)));
  end

  assign hold_expired = settled(8'(lost_q), 8'(HOLD_TICKS));

  // R6: the loss interval cannot expire while sync is present
  a_r6_no_expiry_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_ok) |-> !hold_expired);

endmodule

// File: rtl/cas_db_chan.sv
module cas_db_chan
  import cas_db_pkg::*;
#(
  parameter int unsigned NIB_W        = 4,
  parameter int unsigned STABLE_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [NIB_W-1:0] nib,
  input  logic             tick,
  input  logic             deb_en,
  input  logic             sync_ok,
  input  logic             clr_valid,
  output logic [NIB_W-1:0] acc_o,
  output logic             valid_o
);
  localparam int unsigned CW = $clog2(STABLE_TICKS + 1);

  logic [NIB_W-1:0] cand_q, acc_q;
  logic [CW-1:0]    cnt_q;
  logic             valid_q;

  // Named internal events
  logic bypass_ld, changed, advance, accept;
  assign bypass_ld = hit && !deb_en;
  assign changed   = hit && deb_en && (nib != cand_q);
  assign advance   = tick && deb_en && !changed;
  assign accept    = advance && sync_ok && settled(8'(cnt_q), 8'(STABLE_TICKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q  <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (bypass_ld || changed) begin
        cand_q <= nib;
        cnt_q  <= '0;
      end else if (advance) begin
        cnt_q <= CW'(sat_inc(8'(cnt_q), 8'(STABLE_TICKS)));
      end
      if (bypass_ld && sync_ok) begin
        acc_q   <= nib;
        valid_q <= 1'b1;
      end else if (accept) begin
        acc_q   <= cand_q;
        valid_q <= 1'b1;
      end else if (clr_valid) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign acc_o   = acc_q;
  assign valid_o = valid_q;

  // R4: in debounce mode the accepted value moves only on a tick over a settled candidate
  a_r4_accept_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(deb_en) && (acc_q != $past(acc_q))) |-> $past(tick && (cnt_q == CW'(STABLE_TICKS))));

  // R8: accepted value frozen while unsynchronized
  a_r8_frozen_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sync_ok) |-> $stable(acc_q));

  // R9: valid only rises while synchronized
  a_r9_valid_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(sync_ok));

endmodule

// File: rtl/cas_debouncer.sv
module cas_debouncer
  import cas_db_pkg::*;
#(
  parameter int unsigned NUM_CH       = 30,
  parameter int unsigned CH_W         = 5,
  parameter int unsigned NIB_W        = 4,
  parameter int unsigned STABLE_TICKS = 3,
  parameter int unsigned HOLD_TICKS   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [NIB_W-1:0] wr_nib,
  input  logic             tick,
  input  logic             deb_en,
  input  logic             sync_ok,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [NIB_W-1:0] rd_nib,
  output logic             rd_valid
);
  logic             hold_expired;
  logic             clr_valid;
  logic [NIB_W-1:0] acc_arr [NUM_CH];
  logic [NUM_CH-1:0] valid_vec;

  cas_db_loss_timer #(.HOLD_TICKS(HOLD_TICKS)) u_loss (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .sync_ok     (sync_ok),
    .hold_expired(hold_expired)
  );

  assign clr_valid = !sync_ok && (!deb_en || hold_expired);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CH_W'(g + 1));
    cas_db_chan #(.NIB_W(NIB_W), .STABLE_TICKS(STABLE_TICKS)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .nib      (wr_nib),
      .tick     (tick),
      .deb_en   (deb_en),
      .sync_ok  (sync_ok),
      .clr_valid(clr_valid),
      .acc_o    (acc_arr[g]),
      .valid_o  (valid_vec[g])
    );
  end

  always_comb begin
    rd_nib   = '0;
    rd_valid = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch == CH_W'(i + 1)) begin
        rd_nib   = acc_arr[i];
        rd_valid = valid_vec[i];
      end
    end
  end

  // R6: once the hold interval has run out, no channel stays valid
  a_r6_hold_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_ok && hold_expired) |=> (valid_vec == '0));

  // R7: bypass mode drops all flags on the clock after sync loss
  a_r7_bypass_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_ok && !deb_en) |=> (valid_vec == '0));

endmodule

// File: tb/cas_debouncer_test.sv
module cas_debouncer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_ch = '0;
  logic [3:0] wr_nib = '0;
  logic       tick = 1'b0;
  logic       deb_en = 1'b0;
  logic       sync_ok = 1'b0;
  logic [4:0] rd_ch = '0;
  logic [3:0] rd_nib;
  logic       rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cas_debouncer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_nib(wr_nib),
    .tick(tick), .deb_en(deb_en), .sync_ok(sync_ok), .rd_ch(rd_ch),
    .rd_nib(rd_nib), .rd_valid(rd_valid)
  );

  function automatic logic [3:0] pat_a(input int ch); return 4'((ch * 7 + 3) & 15); endfunction
  function automatic logic [3:0] pat_b(input int ch); return 4'((ch * 5 + 1) & 15); endfunction

  task automatic wr(input int ch, input logic [3:0] n);
    @(negedge clk); wr_en = 1'b1; wr_ch = 5'(ch); wr_nib = n;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic chk(input string req, input int ch, input logic [3:0] en, input logic ev);
    rd_ch = 5'(ch);
    #1;
    checks++;
    if (rd_nib !== en || rd_valid !== ev) begin
      errors++;
      $display("FAIL %s ch %0d: nib=%0h valid=%0b expected nib=%0h valid=%0b",
               req, ch, rd_nib, rd_valid, en, ev);
    end
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog expired");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int c = 1; c <= 30; c++) chk("R1", c, 4'h0, 1'b0);

    // R3: bypass, synced
    sync_ok = 1'b1;
    for (int c = 1; c <= 30; c++) begin
      wr(c, pat_a(c));
      chk("R3", c, pat_a(c), 1'b1);
    end

    // R2: out-of-range writes ignored, out-of-range reads empty
    wr(0, 4'hF);
    wr(31, 4'hF);
    for (int c = 1; c <= 30; c++) chk("R2", c, pat_a(c), 1'b1);
    chk("R2", 0, 4'h0, 1'b0);
    chk("R2", 31, 4'h0, 1'b0);

    // R4: debounce timing
    @(negedge clk); deb_en = 1'b1;
    for (int c = 1; c <= 30; c++) wr(c, pat_b(c));
    for (int t = 1; t <= 3; t++) begin
      do_tick();
      for (int c = 1; c <= 30; c++) chk("R4", c, pat_a(c), 1'b1);
    end
    do_tick();
    for (int c = 1; c <= 30; c++) chk("R4", c, pat_b(c), 1'b1);

    // R5: glitch replaced before acceptance
    wr(3, ~pat_b(3));
    do_tick();
    wr(3, pat_b(3));
    for (int t = 1; t <= 5; t++) begin
      do_tick();
      chk("R5", 3, pat_b(3), 1'b1);
    end

    // R6: hold through two ticks, clear after third
    @(negedge clk); sync_ok = 1'b0;
    // R8: candidate tracks during loss
    wr(9, 4'hA);
    for (int t = 1; t <= 2; t++) begin
      do_tick();
      @(negedge clk);
      for (int c = 1; c <= 30; c++) chk("R6", c, pat_b(c), 1'b1);
    end
    do_tick();
    @(negedge clk);
    for (int c = 1; c <= 30; c++) chk("R6", c, pat_b(c), 1'b0);
    do_tick();
    chk("R8", 9, pat_b(9), 1'b0);

    // R8: sync returns, first tick restores
    @(negedge clk); sync_ok = 1'b1;
    @(negedge clk);
    chk("R8", 1, pat_b(1), 1'b0);
    do_tick();
    for (int c = 1; c <= 30; c++)
      chk("R8", c, (c == 9) ? 4'hA : pat_b(c), 1'b1);

    // R7: bypass sync loss
    @(negedge clk); deb_en = 1'b0;
    @(negedge clk); sync_ok = 1'b0;
    @(negedge clk);
    for (int c = 1; c <= 30; c++)
      chk("R7", c, (c == 9) ? 4'hA : pat_b(c), 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule